// File: doc/BRIEF.md
# Nested Indirect Register Access Engine

This block sits on the host side of a management bus and turns one register request into the series of transfers needed to reach a register that lies behind one or two layers of command/data indirection. A switch-level request reaches a register set of the switch through a command register (offset 0) and a data register (offset 1) at the switch's bus address. A PHY-level request goes one layer deeper. It loads a second command/data pair, command at register 0x18 and data at 0x19, inside a global register group of the switch. Every access to that pair is itself a switch-level indirect transfer.

A request is accepted through a valid/ready handshake. It carries the level, a device number, a register number, write data and a write flag. The engine runs the whole sequence on a simple parallel management port, where each transfer is held until the target acknowledges it. When it finishes, it pulses a done strobe together with the 16-bit result and an error flag. Every busy poll is limited by a programmable attempt count. When the configured bus address is zero, the switch layer is bypassed and the device and register numbers go straight onto the port.

Top module: `nia_engine`

## Requirements
- R1: In indirect mode (nonzero bus address), every switch-level command is preceded by reads of register 0 at the bus address, repeated until bit 15 (busy) reads 0. No write to register 0 or register 1 is issued before that poll succeeds.
- R2: For a switch-level write, the write data is written to register 1 before the command word is written to register 0.
- R3: The command word has bit 15 set, bit 12 set, bits 11:10 = 2'b10 for a read or 2'b01 for a write, the device number in bits 9:5 and the register number in bits 4:0. All other bits are 0.
- R4: After the command is issued, register 0 is polled again until busy clears. A read then fetches register 1 and returns only bits 15:0 of the port read data.
- R5: A PHY-level access uses the same command encoding, written to register 0x18 of the global group (device parameter, default 0x1C). Write data goes to 0x19 before the command. Completion is found by reading 0x18 until bit 15 is 0, and a read then returns 0x19. Every one of these accesses is a switch-level transfer.
- R6: With bus address 0, a switch-level request is a single port transfer whose address is the device number and whose register is the register number.
- R7: A busy poll that sees busy on max(limit,1) consecutive reads ends the request with the error flag set and result 0, and the engine returns to ready.
- R8: The request ready output is high only while the engine is idle and drops the cycle after a request is accepted. The done strobe is exactly one cycle wide.
- R9: After reset, ready is 1, done is 0 and the port valid is 0.
- R10: A port transfer keeps its valid, write flag, address, register and write data unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bus_addr | input | 5 | Switch bus address; 0 selects direct mode |
| cfg_poll_limit | input | POLL_W | Maximum busy reads per poll |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted when valid |
| req_phy | input | 1 | 1 = PHY-level access, 0 = switch-level access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Device number |
| req_reg | input | 5 | Register number |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_err | output | 1 | Poll timeout on the completed request |
| rsp_rdata | output | 16 | Read result (0 for writes and errors) |
| mg_valid | output | 1 | Port transfer requested |
| mg_write | output | 1 | Port transfer is a write |
| mg_addr | output | 5 | Port bus address |
| mg_reg | output | 5 | Port register number |
| mg_wdata | output | BUS_W | Port write data |
| mg_ack | input | 1 | Port transfer acknowledge |
| mg_rdata | input | BUS_W | Port read data, valid with the acknowledge |

## Verification
The assertions assume that the target raises the acknowledge only while a transfer is requested, keeps it up for a single cycle, and drives read data in that same cycle. They also assume that the bus address stays constant while a request is in progress. The bench's switch model registers its acknowledge for one cycle only when valid is high and the previous cycle carried no acknowledge, with a programmable wait before it. The bench changes the bus address and the poll limit only between requests, while the engine is ready.

// File: rtl/nia_pkg.sv
package nia_pkg;
   localparam int unsigned FLD_W    = 5;
   localparam int unsigned BUSY_BIT = 15;
   localparam logic [FLD_W-1:0] SW_CMD_REG   = 5'h00;
   localparam logic [FLD_W-1:0] SW_DATA_REG  = 5'h01;
   localparam logic [FLD_W-1:0] PHY_CMD_REG  = 5'h18;
   localparam logic [FLD_W-1:0] PHY_DATA_REG = 5'h19;

   typedef enum logic [2:0] {O_IDLE, O_PRE, O_WDAT, O_CMD, O_POST, O_RDAT, O_DIR} ostate_t;
   typedef enum logic [2:0] {I_IDLE, I_PASS, I_WDAT, I_CMD, I_POLL, I_RDAT} istate_t;

   // busy | clause bit | opcode | device | register
   function automatic logic [15:0] cmd_word(input logic wr, input logic [FLD_W-1:0] dev,
                                            input logic [FLD_W-1:0] rg);
      cmd_word = 16'h9000 | (wr ? 16'h0400 : 16'h0800) | {6'd0, dev, rg};
   endfunction
endpackage

// File: rtl/nia_poll_ctr.sv
module nia_poll_ctr #(
   parameter int POLL_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   input  logic [POLL_W-1:0] limit,
   output logic              last
);
   logic [POLL_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (clr)                   cnt <= '0;
      else if (step && (cnt != '1))   cnt <= cnt + 1'b1;
   end

   // current attempt is the final one allowed (a limit of 0 allows one)
   assign last = ({1'b0, cnt} + {{POLL_W{1'b0}}, 1'b1}) >= {1'b0, limit};

   a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && last) |=> (cnt >= limit) || (cnt == '1));
endmodule

// File: rtl/nia_outer.sv
module nia_outer import nia_pkg::*; #(
   parameter int BUS_W     = 32,
   parameter int POLL_W    = 8,
   parameter bit DIRECT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLD_W-1:0]  bus_addr,
   input  logic [POLL_W-1:0] poll_limit,
   input  logic              start,
   input  logic              we,
   input  logic [FLD_W-1:0]  dev,
   input  logic [FLD_W-1:0]  rg,
   input  logic [15:0]       wdata,
   output logic              idle,
   output logic              done,
   output logic              err,
   output logic [15:0]       rdata,
   output logic              mg_valid,
   output logic              mg_write,
   output logic [FLD_W-1:0]  mg_addr,
   output logic [FLD_W-1:0]  mg_reg,
   output logic [BUS_W-1:0]  mg_wdata,
   input  logic              mg_ack,
   input  logic [BUS_W-1:0]  mg_rdata
);
   initial assert (BUS_W >= 16) else $error("nia_outer: BUS_W below 16");

   ostate_t st, nxt;
   logic we_q, direct_q, direct_sel, fin, fin_err, last, busy_rd, poll_st;
   logic [FLD_W-1:0] dev_q, rg_q, ba_q;
   logic [15:0] wd_q, fin_data;
   logic unused_rd_all;

   assign unused_rd_all = ^mg_rdata;

   if (DIRECT_EN) begin : g_direct
      assign direct_sel = (bus_addr == '0);
   end else begin : g_indirect_only
      assign direct_sel = 1'b0;
   end

   assign idle    = (st == O_IDLE);
   assign busy_rd = mg_rdata[BUSY_BIT];
   assign poll_st = (st == O_PRE) || (st == O_POST);

   nia_poll_ctr #(.POLL_W(POLL_W)) u_poll (
      .clk(clk), .rst_n(rst_n), .clr(!poll_st), .step(poll_st && mg_ack && busy_rd),
      .limit(poll_limit), .last(last));

   always_comb begin
      mg_valid = (st != O_IDLE);
      mg_write = 1'b0;
      mg_addr  = ba_q;
      mg_reg   = SW_CMD_REG;
      mg_wdata = '0;
      case (st)
         O_WDAT: begin mg_write = 1'b1; mg_reg = SW_DATA_REG; mg_wdata = BUS_W'(wd_q); end
         O_CMD:  begin mg_write = 1'b1; mg_wdata = BUS_W'(cmd_word(we_q, dev_q, rg_q)); end
         O_RDAT: mg_reg = SW_DATA_REG;
         O_DIR:  begin mg_write = we_q; mg_addr = dev_q; mg_reg = rg_q; mg_wdata = BUS_W'(wd_q); end
         default: ;
      endcase
   end

   always_comb begin
      nxt = st; fin = 1'b0; fin_err = 1'b0; fin_data = '0;
      case (st)
         O_IDLE: if (start) nxt = direct_sel ? O_DIR : O_PRE;
         O_PRE: if (mg_ack) begin
            if (!busy_rd)  nxt = we_q ? O_WDAT : O_CMD;
            else if (last) begin fin = 1'b1; fin_err = 1'b1; end
         end
         O_WDAT: if (mg_ack) nxt = O_CMD;
         O_CMD:  if (mg_ack) nxt = O_POST;
         O_POST: if (mg_ack) begin
            if (!busy_rd) begin
               if (we_q) fin = 1'b1;
               else      nxt = O_RDAT;
            end else if (last) begin fin = 1'b1; fin_err = 1'b1; end
         end
         O_RDAT: if (mg_ack) begin fin = 1'b1; fin_data = mg_rdata[15:0]; end
         O_DIR:  if (mg_ack) begin fin = 1'b1; fin_data = we_q ? 16'h0 : mg_rdata[15:0]; end
         default: nxt = O_IDLE;
      endcase
      if (fin) nxt = O_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= O_IDLE; done <= 1'b0; err <= 1'b0; rdata <= '0;
         we_q <= 1'b0; direct_q <= 1'b0; dev_q <= '0; rg_q <= '0; wd_q <= '0; ba_q <= '0;
      end else begin
         st   <= nxt;
         done <= fin;
         if (fin) begin err <= fin_err; rdata <= fin_data; end
         if (idle && start) begin
            we_q <= we; dev_q <= dev; rg_q <= rg; wd_q <= wdata;
            ba_q <= bus_addr; direct_q <= direct_sel;
         end
      end
   end

   // checker state: a free poll and a data load seen in the current transfer
   logic free_seen, data_loaded;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         free_seen <= 1'b0; data_loaded <= 1'b0;
      end else if (idle && start) begin
         free_seen <= 1'b0; data_loaded <= 1'b0;
      end else if (mg_valid && mg_ack) begin
         if (!mg_write && mg_reg == SW_CMD_REG && !busy_rd) free_seen <= 1'b1;
         if (mg_write && mg_reg == SW_DATA_REG)              data_loaded <= 1'b1;
      end
   end

   a_r1_poll_before_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (mg_valid && mg_write && !direct_q) |-> free_seen);
   a_r2_data_before_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (mg_valid && mg_write && !direct_q && mg_reg == SW_CMD_REG && mg_wdata[10]) |-> data_loaded);
   a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (mg_valid && !mg_ack) |=> (mg_valid && $stable(mg_write) && $stable(mg_addr)
                                 && $stable(mg_reg) && $stable(mg_wdata)));
endmodule

// File: rtl/nia_engine.sv
module nia_engine import nia_pkg::*; #(
   parameter int              BUS_W     = 32,
   parameter int              POLL_W    = 8,
   parameter logic [4:0]      PHY_GRP   = 5'h1C,
   parameter bit              DIRECT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        cfg_bus_addr,
   input  logic [POLL_W-1:0] cfg_poll_limit,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_phy,
   input  logic              req_write,
   input  logic [4:0]        req_dev,
   input  logic [4:0]        req_reg,
   input  logic [15:0]       req_wdata,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [15:0]       rsp_rdata,
   output logic              mg_valid,
   output logic              mg_write,
   output logic [4:0]        mg_addr,
   output logic [4:0]        mg_reg,
   output logic [BUS_W-1:0]  mg_wdata,
   input  logic              mg_ack,
   input  logic [BUS_W-1:0]  mg_rdata
);
   initial assert (BUS_W >= 16 && POLL_W >= 1) else $error("nia_engine: bad parameters");

   istate_t ist, nxt;
   logic we_q, o_we, o_start, o_idle, o_done, o_err, i_last, fin, fin_err;
   logic [FLD_W-1:0] dev_q, rg_q, o_dev, o_rg;
   logic [15:0] wd_q, o_wd, o_rdata, fin_data;

   assign req_ready = (ist == I_IDLE);
   assign o_start   = (ist != I_IDLE) && o_idle && !o_done;

   always_comb begin
      o_we = 1'b0; o_dev = PHY_GRP; o_rg = PHY_CMD_REG; o_wd = '0;
      case (ist)
         I_PASS: begin o_we = we_q; o_dev = dev_q; o_rg = rg_q; o_wd = wd_q; end
         I_WDAT: begin o_we = 1'b1; o_rg = PHY_DATA_REG; o_wd = wd_q; end
         I_CMD:  begin o_we = 1'b1; o_wd = cmd_word(we_q, dev_q, rg_q); end
         I_RDAT: o_rg = PHY_DATA_REG;
         default: ;
      endcase
   end

   nia_outer #(.BUS_W(BUS_W), .POLL_W(POLL_W), .DIRECT_EN(DIRECT_EN)) u_outer (
      .clk(clk), .rst_n(rst_n), .bus_addr(cfg_bus_addr), .poll_limit(cfg_poll_limit),
      .start(o_start), .we(o_we), .dev(o_dev), .rg(o_rg), .wdata(o_wd),
      .idle(o_idle), .done(o_done), .err(o_err), .rdata(o_rdata),
      .mg_valid(mg_valid), .mg_write(mg_write), .mg_addr(mg_addr), .mg_reg(mg_reg),
      .mg_wdata(mg_wdata), .mg_ack(mg_ack), .mg_rdata(mg_rdata));

   nia_poll_ctr #(.POLL_W(POLL_W)) u_ipoll (
      .clk(clk), .rst_n(rst_n), .clr(ist != I_POLL),
      .step((ist == I_POLL) && o_done && !o_err && o_rdata[BUSY_BIT]),
      .limit(cfg_poll_limit), .last(i_last));

   always_comb begin
      nxt = ist; fin = 1'b0; fin_err = 1'b0; fin_data = '0;
      case (ist)
         I_IDLE: if (req_valid) nxt = req_phy ? (req_write ? I_WDAT : I_CMD) : I_PASS;
         default: if (o_done) begin
            if (o_err) begin fin = 1'b1; fin_err = 1'b1; end
            else case (ist)
               I_PASS, I_RDAT: begin fin = 1'b1; fin_data = o_rdata; end
               I_WDAT: nxt = I_CMD;
               I_CMD:  nxt = I_POLL;
               I_POLL: begin
                  if (!o_rdata[BUSY_BIT]) begin
                     if (we_q) fin = 1'b1;
                     else      nxt = I_RDAT;
                  end else if (i_last) begin fin = 1'b1; fin_err = 1'b1; end
               end
               default: ;
            endcase
         end
      endcase
      if (fin) nxt = I_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ist <= I_IDLE; rsp_done <= 1'b0; rsp_err <= 1'b0; rsp_rdata <= '0;
         we_q <= 1'b0; dev_q <= '0; rg_q <= '0; wd_q <= '0;
      end else begin
         ist      <= nxt;
         rsp_done <= fin;
         if (fin) begin rsp_err <= fin_err; rsp_rdata <= fin_data; end
         if (req_ready && req_valid) begin
            we_q <= req_write; dev_q <= req_dev; rg_q <= req_reg; wd_q <= req_wdata;
         end
      end
   end

   a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
   a_r7_err_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_done |-> $stable(rsp_err));
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mg_valid);
endmodule

// File: tb/tb_nia_engine.sv
`timescale 1ns/1ps
module tb_nia_engine;
   localparam int BUS_W = 32;
   localparam int POLL_W = 8;
   localparam logic [4:0] GRP = 5'h1C;
   localparam logic [4:0] SWA = 5'h03;

   logic clk = 1'b0, rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [4:0] cfg_bus_addr = '0;
   logic [POLL_W-1:0] cfg_poll_limit = 8'd8;
   logic req_valid = 0, req_phy = 0, req_write = 0;
   logic [4:0] req_dev = '0, req_reg = '0;
   logic [15:0] req_wdata = '0;
   logic req_ready, rsp_done, rsp_err;
   logic [15:0] rsp_rdata;
   logic mg_valid, mg_write, mg_ack;
   logic [4:0] mg_addr, mg_reg;
   logic [BUS_W-1:0] mg_wdata, mg_rdata;

   nia_engine #(.BUS_W(BUS_W), .POLL_W(POLL_W), .PHY_GRP(GRP)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_bus_addr(cfg_bus_addr), .cfg_poll_limit(cfg_poll_limit),
      .req_valid(req_valid), .req_ready(req_ready), .req_phy(req_phy), .req_write(req_write),
      .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .mg_valid(mg_valid), .mg_write(mg_write), .mg_addr(mg_addr), .mg_reg(mg_reg),
      .mg_wdata(mg_wdata), .mg_ack(mg_ack), .mg_rdata(mg_rdata));

   int checks = 0, errors = 0;

   // ---------------- switch model ----------------
   logic [15:0] swr [0:31][0:31];
   logic [15:0] phr [0:31][0:31];
   logic [15:0] o_cmd, o_data, i_cmd;
   int o_busy, o_post, i_busy, i_post, ack_dly, ack_cnt, stab_bad;
   int log_n;
   logic [4:0]  log_a [0:63];
   logic [4:0]  log_r [0:63];
   logic        log_w [0:63];
   logic [15:0] log_d [0:63];
   logic waiting;
   logic [4:0] h_a, h_r; logic h_w; logic [BUS_W-1:0] h_d;

   function automatic logic [15:0] exp_cmd(input bit wr, input logic [4:0] d, input logic [4:0] r);
      return {1'b1, 2'b00, 1'b1, (wr ? 2'b01 : 2'b10), d, r};
   endfunction

   task automatic sw_wr(input logic [4:0] d, input logic [4:0] r, input logic [15:0] v);
      if (d == GRP && r == 5'h18) begin
         i_cmd = v; i_busy = i_post;
         if (v[11:10] == 2'b10) swr[GRP][5'h19] = phr[v[9:5]][v[4:0]];
         else if (v[11:10] == 2'b01) phr[v[9:5]][v[4:0]] = swr[GRP][5'h19];
      end else swr[d][r] = v;
   endtask

   task automatic sw_rd(input logic [4:0] d, input logic [4:0] r, output logic [15:0] v);
      if (d == GRP && r == 5'h18) begin
         if (i_busy > 0) begin i_busy--; v = i_cmd | 16'h8000; end
         else v = i_cmd & 16'h7FFF;
      end else v = swr[d][r];
   endtask

   task automatic serve(output logic [15:0] v);
      v = 16'hFFFF;
      if (cfg_bus_addr == 5'd0) begin
         if (mg_write) sw_wr(mg_addr, mg_reg, mg_wdata[15:0]);
         else sw_rd(mg_addr, mg_reg, v);
      end else if (mg_addr == SWA) begin
         if (mg_write && mg_reg == 5'd0) begin
            o_cmd = mg_wdata[15:0]; o_busy = o_post;
            if (o_cmd[11:10] == 2'b10) sw_rd(o_cmd[9:5], o_cmd[4:0], o_data);
            else if (o_cmd[11:10] == 2'b01) sw_wr(o_cmd[9:5], o_cmd[4:0], o_data);
         end else if (mg_write && mg_reg == 5'd1) o_data = mg_wdata[15:0];
         else if (!mg_write && mg_reg == 5'd0) begin
            if (o_busy > 0) begin o_busy--; v = o_cmd | 16'h8000; end
            else v = o_cmd & 16'h7FFF;
         end else if (!mg_write && mg_reg == 5'd1) v = o_data;
      end
   endtask

   always @(posedge clk) begin
      logic [15:0] v;
      if (!rst_n) begin
         mg_ack <= 1'b0; mg_rdata <= '0; ack_cnt = 0; waiting = 1'b0;
      end else if (mg_valid && !mg_ack) begin
         if (waiting && (mg_addr != h_a || mg_reg != h_r || mg_write != h_w || mg_wdata != h_d))
            stab_bad++;
         h_a = mg_addr; h_r = mg_reg; h_w = mg_write; h_d = mg_wdata; waiting = 1'b1;
         if (ack_cnt >= ack_dly) begin
            ack_cnt = 0; waiting = 1'b0;
            serve(v);
            mg_ack <= 1'b1;
            mg_rdata <= {16'hA5A5, v};
            if (log_n < 64) begin
               log_a[log_n] = mg_addr; log_r[log_n] = mg_reg; log_w[log_n] = mg_write;
               log_d[log_n] = mg_write ? mg_wdata[15:0] : v;
            end
            log_n++;
         end else ack_cnt++;
      end else mg_ack <= 1'b0;
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic setup(input logic [4:0] ba, input int lim, input int ob, input int op,
                        input int ip, input int dly);
      @(negedge clk);
      cfg_bus_addr = ba; cfg_poll_limit = POLL_W'(lim);
      o_busy = ob; o_post = op; i_busy = 0; i_post = ip; ack_dly = dly; log_n = 0;
   endtask

   task automatic do_req(input bit phy, input bit wr, input logic [4:0] d, input logic [4:0] r,
                         input logic [15:0] wd, output logic [15:0] rd, output bit er);
      int n;
      @(negedge clk);
      chk(req_ready == 1'b1, "R8 ready while idle", 32'(req_ready), 32'd1);
      req_valid = 1'b1; req_phy = phy; req_write = wr; req_dev = d; req_reg = r; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R8 ready low after accept", 32'(req_ready), 32'd0);
      n = 0;
      while (!rsp_done && n < 20000) begin @(negedge clk); n++; end
      rd = rsp_rdata; er = rsp_err;
      @(negedge clk);
      chk(rsp_done == 1'b0 && req_ready == 1'b1, "R8 done one cycle, ready back",
          {rsp_done, req_ready}, 32'b01);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk(req_ready == 1'b1, "R9 reset ready", 32'(req_ready), 32'd1);
      chk(rsp_done == 1'b0, "R9 reset done", 32'(rsp_done), 32'd0);
      chk(mg_valid == 1'b0, "R9 reset port valid", 32'(mg_valid), 32'd0);
   endtask

   task automatic t_outer_write();
      logic [15:0] rd; bit er;
      setup(SWA, 8, 2, 1, 0, 1);
      do_req(1'b0, 1'b1, 5'd4, 5'd6, 16'hBEEF, rd, er);
      chk(log_n == 7, "R1 R4 transfer count (3 pre polls, data, cmd, 2 post polls)", 32'(log_n), 32'd7);
      chk(!log_w[0] && !log_w[1] && !log_w[2] && log_r[2] == 5'd0 && log_a[2] == SWA,
          "R1 polls precede writes", {log_w[0], log_w[1], log_w[2]}, 32'd0);
      chk(log_w[3] && log_r[3] == 5'd1 && log_d[3] == 16'hBEEF, "R2 data register loaded first",
          32'(log_d[3]), 32'hBEEF);
      chk(log_w[4] && log_r[4] == 5'd0 && log_d[4] == 16'h9486, "R3 write command word",
          32'(log_d[4]), 32'h9486);
      chk(!log_w[6] && log_r[6] == 5'd0, "R4 post poll read", 32'(log_r[6]), 32'd0);
      chk(swr[4][6] == 16'hBEEF && !er, "R2 register written", 32'(swr[4][6]), 32'hBEEF);
   endtask

   task automatic t_outer_read();
      logic [15:0] rd; bit er;
      setup(SWA, 8, 0, 0, 0, 0);
      swr[4][7] = 16'h1234;
      do_req(1'b0, 1'b0, 5'd4, 5'd7, 16'h0, rd, er);
      chk(log_n == 4, "R4 read transfer count", 32'(log_n), 32'd4);
      chk(log_d[1] == exp_cmd(1'b0, 5'd4, 5'd7) && log_d[1] == 16'h9887, "R3 read command word",
          32'(log_d[1]), 32'h9887);
      chk(!log_w[3] && log_r[3] == 5'd1, "R4 data register fetched last", 32'(log_r[3]), 32'd1);
      chk(rd == 16'h1234 && !er, "R4 read result masked to 16 bits", 32'(rd), 32'h1234);
   endtask

   task automatic t_direct();
      logic [15:0] rd; bit er;
      setup(5'd0, 8, 0, 0, 0, 1);
      do_req(1'b0, 1'b1, 5'd5, 5'd2, 16'h0F0F, rd, er);
      chk(log_n == 1 && log_a[0] == 5'd5 && log_r[0] == 5'd2 && log_w[0],
          "R6 direct write single transfer", 32'(log_n), 32'd1);
      chk(swr[5][2] == 16'h0F0F, "R6 direct write lands", 32'(swr[5][2]), 32'h0F0F);
      setup(5'd0, 8, 0, 0, 0, 0);
      do_req(1'b0, 1'b0, 5'd5, 5'd2, 16'h0, rd, er);
      chk(log_n == 1 && !log_w[0] && rd == 16'h0F0F && !er, "R6 direct read", 32'(rd), 32'h0F0F);
   endtask

   task automatic t_phy_write(input int dly);
      logic [15:0] rd; bit er;
      setup(SWA, 8, 0, 0, 2, dly);
      stab_bad = 0;
      do_req(1'b1, 1'b1, 5'd2, 5'h10, 16'hCAFE, rd, er);
      chk(log_n == 20, "R5 PHY write transfer count", 32'(log_n), 32'd20);
      chk(log_d[1] == 16'hCAFE && log_d[2] == 16'h9799, "R5 data to 0x19 first",
          32'(log_d[2]), 32'h9799);
      chk(log_d[5] == 16'h9450 && log_d[6] == 16'h9798, "R5 R3 inner command to 0x18",
          {log_d[5], log_d[6]}, {16'h9450, 16'h9798});
      chk(phr[2][16] == 16'hCAFE && !er, "R5 PHY register written", 32'(phr[2][16]), 32'hCAFE);
      chk(stab_bad == 0, "R10 transfer held until ack", 32'(stab_bad), 32'd0);
   endtask

   task automatic t_phy_read();
      logic [15:0] rd; bit er;
      setup(SWA, 8, 0, 0, 0, 0);
      phr[3][1] = 16'h5A5A;
      do_req(1'b1, 1'b0, 5'd3, 5'd1, 16'h0, rd, er);
      chk(log_n == 12, "R5 PHY read transfer count", 32'(log_n), 32'd12);
      chk(log_d[1] == exp_cmd(1'b0, 5'd3, 5'd1), "R5 inner read command", 32'(log_d[1]), 32'h9861);
      chk(rd == 16'h5A5A && !er, "R5 PHY read result", 32'(rd), 32'h5A5A);
   endtask

   task automatic t_timeout();
      logic [15:0] rd; bit er;
      setup(SWA, 3, 10, 0, 0, 0);
      do_req(1'b0, 1'b0, 5'd4, 5'd7, 16'h0, rd, er);
      chk(er && rd == 16'h0 && log_n == 3, "R7 outer poll gives up after limit", 32'(log_n), 32'd3);
      setup(SWA, 0, 10, 0, 0, 0);
      do_req(1'b0, 1'b1, 5'd4, 5'd7, 16'h1111, rd, er);
      chk(er && log_n == 1, "R7 zero limit allows one attempt", 32'(log_n), 32'd1);
      setup(SWA, 2, 0, 0, 50, 0);
      do_req(1'b1, 1'b0, 5'd3, 5'd1, 16'h0, rd, er);
      chk(er && rd == 16'h0 && log_n == 12, "R7 inner poll gives up after limit", 32'(log_n), 32'd12);
      setup(SWA, 8, 0, 0, 0, 0);
      do_req(1'b0, 1'b0, 5'd4, 5'd7, 16'h0, rd, er);
      chk(!er && rd == 16'h1234, "R7 engine usable after timeout", 32'(rd), 32'h1234);
   endtask

   initial begin
      for (int i = 0; i < 32; i++)
         for (int j = 0; j < 32; j++) begin swr[i][j] = 16'h0; phr[i][j] = 16'h0; end
      o_cmd = 0; o_data = 0; i_cmd = 0; o_busy = 0; o_post = 0; i_busy = 0; i_post = 0;
      ack_dly = 0; log_n = 0; stab_bad = 0;
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_outer_write();
      t_outer_read();
      t_direct();
      t_phy_write(0);
      t_phy_write(2);
      t_phy_read();
      t_timeout();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule